// File: doc/BRIEF.md
# Power-Down Wake and Clock-Lock Controller

This block sequences a microcontroller core into and out of its low-power halt state. The core raises a one-cycle request to halt. Configuration inputs then decide whether the slow 32 kHz oscillator keeps running during the halt, and which interrupt sources may end it: the wake timer, the SPI port or external interrupt 0. Each source can wake the device only when its own gating conditions hold. A wake produces a single-cycle pulse that carries a source code, and the core resumes at once.

After a wake, the core clock runs but is not yet trustworthy. The block models the PLL settling time as a count of 32 kHz ticks, and exposes the result as a lock flag that software polls in a status byte. When the oscillator was shut off for the halt, a longer crystal start-up count runs first. On power-up, the block holds the core in reset for a parameterised number of ticks. The block also registers a clock-divider selection and turns it into a core clock-enable strobe, so software can run the core slower instead of halting it.

Top module: `pd_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `core_rst_n`, `pll_locked`, `in_pd` and `wake_pulse` are 0 and `osc_pwr_on` is 1. After `rst_n` rises, `core_rst_n` and `pll_locked` become 1 at the clock edge that samples the RST_TICKS-th asserted `tick_32k`.
- R2: A `pd_req` sampled while the core is released and not halted sets `in_pd` and clears `pll_locked` at the next edge.
- R3: While halted, `osc_pwr_on` is the inverse of the `osc_pd_cfg` value sampled together with the accepted `pd_req`. Outside the halt, `osc_pwr_on` is 1.
- R4: A timer interrupt (`tmr_irq`) ends the halt only when `tmr_en` is 1 and the oscillator was left running for this halt.
- R5: An SPI interrupt (`spi_irq`) ends the halt only when both `spi_wake_en` and `spi_ie` are 1.
- R6: An external interrupt (`ext0_irq`) ends the halt only when both `ext0_wake_en` and `ext0_ie` are 1.
- R7: A wake raises `wake_pulse` for exactly one cycle, in the same cycle that `in_pd` falls. `wake_src` then holds 1 for the timer, 2 for SPI and 3 for the external pin. When several sources qualify, the lowest code wins.
- R8: Interrupts that arrive while the device is not halted never produce `wake_pulse`.
- R9: After a wake with the oscillator kept running, `pll_locked` becomes 1 at the edge that samples the LOCK_TICKS-th tick after the wake.
- R10: After a wake with the oscillator shut off, XTAL_TICKS ticks are counted first, then LOCK_TICKS ticks, before `pll_locked` becomes 1.
- R11: `ctrl_rd` bit 6 equals `pll_locked`, bit 4 equals `osc_pd_cfg`, bits [DIV_W-1:0] equal `core_div`, and all other bits are 0. `core_div` is `clkdiv_cfg` registered once.
- R12: While the core is released and not halted, `core_clk_en` is 1 on one cycle in every 2^`core_div` cycles, and its phase counter restarts at 0 on release. In reset or halt it is 0.
- R13: `pd_req` has no effect during the power-on hold or while already halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| tick_32k | input | 1 | One-cycle strobe per 32 kHz period |
| pd_req | input | 1 | Halt request from the core |
| osc_pd_cfg | input | 1 | 1 = shut the 32 kHz oscillator off during the halt |
| clkdiv_cfg | input | DIV_W | Core clock divider exponent |
| tmr_en | input | 1 | Wake timer enabled |
| tmr_irq | input | 1 | Wake timer interrupt request |
| spi_wake_en | input | 1 | Allow SPI to end the halt |
| spi_ie | input | 1 | SPI interrupt enable |
| spi_irq | input | 1 | SPI interrupt request |
| ext0_wake_en | input | 1 | Allow external interrupt 0 to end the halt |
| ext0_ie | input | 1 | External interrupt 0 enable |
| ext0_irq | input | 1 | External interrupt 0 request |
| core_rst_n | output | 1 | Core reset release, active low |
| in_pd | output | 1 | Device is halted |
| osc_pwr_on | output | 1 | 32 kHz oscillator power |
| pll_locked | output | 1 | Core clock has settled |
| core_div | output | DIV_W | Registered divider exponent |
| core_clk_en | output | 1 | Core clock-enable strobe |
| ctrl_rd | output | 8 | Status byte for software polling |
| wake_pulse | output | 1 | One-cycle wake indication |
| wake_src | output | 2 | Code of the waking source |

## Verification
Every registered result, which covers the halt flag, oscillator power, lock flag, wake pulse and code, core release, divider copy and strobe, follows its cause by one clock edge. The status byte's configuration bit, by contrast, follows its input in the same cycle. The bench keeps a behavioural reference that advances on each rising edge from the inputs held since the previous falling edge. It compares every output at the falling edge, so each expectation is taken a full edge after the stimulus that causes it. Tick-counted delays are not computed in closed form. The reference counts the same tick strobes, so a lock flag that rises one tick early or late is caught in the cycle where it differs.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

   typedef enum logic [2:0] {
      ST_POR  = 3'd0,
      ST_RUN  = 3'd1,
      ST_PD   = 3'd2,
      ST_XTAL = 3'd3,
      ST_LOCK = 3'd4
   } pwc_state_e;

   localparam int unsigned N_WAKE_SRC = 3;
   localparam int unsigned SRC_CODE_W = 2;

   localparam logic [SRC_CODE_W-1:0] SRC_NONE  = 2'd0;
   localparam logic [SRC_CODE_W-1:0] SRC_TIMER = 2'd1;
   localparam logic [SRC_CODE_W-1:0] SRC_SPI   = 2'd2;
   localparam logic [SRC_CODE_W-1:0] SRC_EXT0  = 2'd3;

   localparam int unsigned LOCK_BIT_POS = 6;
   localparam int unsigned OSCPD_BIT_POS = 4;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pwc_tick_timer.sv
module pwc_tick_timer #(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);

   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 1) begin : g_bad_width
      $error("pwc_tick_timer: CNT_W must be at least 1");
   end

   assign hit = !clr && tick && (cnt_q == limit - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (hit) cnt_q <= '0;
         else     cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // R9 / R10: a counting phase always starts below its limit and wraps on the hit
   a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (cnt_q < limit));

endmodule

// File: rtl/pwc_wake_arb.sv
module pwc_wake_arb
   import pwc_pkg::*;
#(
   parameter int unsigned NSRC = N_WAKE_SRC
) (
   input  logic                  armed,
   input  logic [NSRC-1:0]       irq,
   input  logic [NSRC-1:0]       ie,
   input  logic [NSRC-1:0]       gate,
   output logic                  any_wake,
   output logic [SRC_CODE_W-1:0] code
);

   logic [NSRC-1:0] qual;

   if (NSRC + 1 > (1 << SRC_CODE_W)) begin : g_bad_nsrc
      $error("pwc_wake_arb: NSRC does not fit the source code width");
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_qual
      assign qual[g] = armed && irq[g] && ie[g] && gate[g];
   end

   assign any_wake = |qual;

   // lowest index wins: scan from the top so the last match is the lowest
   always_comb begin
      code = SRC_NONE;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (qual[i]) code = SRC_CODE_W'(i + 1);
      end
   end

   // R7: a qualifying wake always carries a nonzero code
   always_comb begin
      if (any_wake) a_r7_code_when_wake: assert (code != SRC_NONE);
   end

endmodule

// File: rtl/pwc_clk_en_gen.sv
module pwc_clk_en_gen #(
   parameter int unsigned DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_sel,
   output logic             clk_en
);

   localparam int unsigned PH_W = (1 << DIV_W) - 1;

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] mask;

   for (genvar g = 0; g < PH_W; g++) begin : g_mask
      assign mask[g] = (32'(div_sel) > g);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     phase_q <= '0;
      else if (!run)  phase_q <= '0;
      else            phase_q <= phase_q + PH_W'(1);
   end

   assign clk_en = run && ((phase_q & mask) == '0);

   // R12: first cycle of a running stretch always carries a strobe
   a_r12_strobe_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> clk_en);

endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
   import pwc_pkg::*;
#(
   parameter int unsigned LOCK_TICKS = 33,
   parameter int unsigned XTAL_TICKS = 4915,
   parameter int unsigned RST_TICKS  = 4194,
   parameter int unsigned DIV_W      = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_32k,
   input  logic             pd_req,
   input  logic             osc_pd_cfg,
   input  logic [DIV_W-1:0] clkdiv_cfg,
   input  logic             tmr_en,
   input  logic             tmr_irq,
   input  logic             spi_wake_en,
   input  logic             spi_ie,
   input  logic             spi_irq,
   input  logic             ext0_wake_en,
   input  logic             ext0_ie,
   input  logic             ext0_irq,
   output logic             core_rst_n,
   output logic             in_pd,
   output logic             osc_pwr_on,
   output logic             pll_locked,
   output logic [DIV_W-1:0] core_div,
   output logic             core_clk_en,
   output logic [7:0]       ctrl_rd,
   output logic             wake_pulse,
   output logic [1:0]       wake_src
);

   localparam int unsigned MAX_TICKS = max3(LOCK_TICKS, XTAL_TICKS, RST_TICKS);
   localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

   if (LOCK_TICKS < 1 || XTAL_TICKS < 1 || RST_TICKS < 1) begin : g_bad_ticks
      $error("pd_wake_ctrl: every tick delay must be at least 1");
   end
   if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
      $error("pd_wake_ctrl: DIV_W must lie in 1..3 to fit the status byte");
   end

   pwc_state_e             state_q, state_d;
   logic                   lock_q, lock_d;
   logic                   osc_off_q;
   logic                   pulse_q;
   logic [SRC_CODE_W-1:0]  src_q;
   logic [DIV_W-1:0]       div_q;
   logic                   core_run;
   logic                   accept_pd;
   logic                   timer_clr;
   logic [CNT_W-1:0]       timer_limit;
   logic                   timer_hit;
   logic                   wake_any;
   logic [SRC_CODE_W-1:0]  wake_code;
   logic [N_WAKE_SRC-1:0]  src_irq, src_ie, src_gate;

   // ---- core run state and halt acceptance ----
   assign core_run  = (state_q == ST_RUN) || (state_q == ST_XTAL) || (state_q == ST_LOCK);
   assign accept_pd = core_run && pd_req;

   // ---- wake source qualification; index order sets priority ----
   assign src_irq  = {ext0_irq,     spi_irq,     tmr_irq};
   assign src_ie   = {ext0_ie,      spi_ie,      tmr_en};
   assign src_gate = {ext0_wake_en, spi_wake_en, !osc_off_q};

   pwc_wake_arb #(.NSRC(N_WAKE_SRC)) u_arb (
      .armed    (state_q == ST_PD),
      .irq      (src_irq),
      .ie       (src_ie),
      .gate     (src_gate),
      .any_wake (wake_any),
      .code     (wake_code)
   );

   // ---- shared tick counter for reset hold, crystal start and lock ----
   assign timer_clr = (state_q == ST_RUN) || (state_q == ST_PD);

   always_comb begin
      unique case (state_q)
         ST_POR:  timer_limit = CNT_W'(RST_TICKS);
         ST_XTAL: timer_limit = CNT_W'(XTAL_TICKS);
         default: timer_limit = CNT_W'(LOCK_TICKS);
      endcase
   end

   pwc_tick_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (timer_clr),
      .tick  (tick_32k),
      .limit (timer_limit),
      .hit   (timer_hit)
   );

   // ---- sequencing ----
   always_comb begin
      state_d = state_q;
      lock_d  = lock_q;
      unique case (state_q)
         ST_POR: begin
            if (timer_hit) begin
               state_d = ST_RUN;
               lock_d  = 1'b1;
            end
         end
         ST_RUN: begin
            if (accept_pd) begin
               state_d = ST_PD;
               lock_d  = 1'b0;
            end
         end
         ST_PD: begin
            if (wake_any) state_d = osc_off_q ? ST_XTAL : ST_LOCK;
         end
         ST_XTAL: begin
            if (accept_pd) begin
               state_d = ST_PD;
               lock_d  = 1'b0;
            end else if (timer_hit) begin
               state_d = ST_LOCK;
            end
         end
         ST_LOCK: begin
            if (accept_pd) begin
               state_d = ST_PD;
               lock_d  = 1'b0;
            end else if (timer_hit) begin
               state_d = ST_RUN;
               lock_d  = 1'b1;
            end
         end
         default: begin
            state_d = ST_POR;
            lock_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_POR;
         lock_q    <= 1'b0;
         osc_off_q <= 1'b0;
         pulse_q   <= 1'b0;
         src_q     <= SRC_NONE;
         div_q     <= '0;
      end else begin
         state_q <= state_d;
         lock_q  <= lock_d;
         div_q   <= clkdiv_cfg;
         if (accept_pd) osc_off_q <= osc_pd_cfg;
         pulse_q <= wake_any;
         src_q   <= wake_any ? wake_code : SRC_NONE;
      end
   end

   // ---- core clock strobe from divider exponent ----
   pwc_clk_en_gen #(.DIV_W(DIV_W)) u_clk_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (core_run),
      .div_sel (div_q),
      .clk_en  (core_clk_en)
   );

   // ---- outputs ----
   assign core_rst_n = (state_q != ST_POR);
   assign in_pd      = (state_q == ST_PD);
   assign osc_pwr_on = !((state_q == ST_PD) && osc_off_q);
   assign pll_locked = lock_q;
   assign core_div   = div_q;
   assign wake_pulse = pulse_q;
   assign wake_src   = src_q;

   always_comb begin
      ctrl_rd                = '0;
      ctrl_rd[LOCK_BIT_POS]  = lock_q;
      ctrl_rd[OSCPD_BIT_POS] = osc_pd_cfg;
      ctrl_rd[DIV_W-1:0]     = div_q;
   end

   // ---- assertions ----
   a_r1_unlocked_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !core_rst_n |-> !pll_locked);

   a_r2_unlocked_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
      in_pd |-> !pll_locked);

   a_r3_osc_on_when_awake: assert property (@(posedge clk) disable iff (!rst_n)
      !in_pd |-> osc_pwr_on);

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   a_r7_pulse_has_code: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (wake_src != SRC_NONE));

   a_r8_pulse_only_from_pd: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> ($past(in_pd) && !in_pd));

   a_r12_no_strobe_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
      (in_pd || !core_rst_n) |-> !core_clk_en);

   a_r13_pd_ignored_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst_n && pd_req) |=> !in_pd);

endmodule

// File: tb/pd_wake_ctrl_tb.sv
module pd_wake_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LOCK_T     = 3;
   localparam int XTAL_T     = 5;
   localparam int RST_T      = 4;
   localparam int DW         = 3;
   localparam int TICK_EVERY = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_32k = 1'b0;
   logic pd_req = 1'b0;
   logic osc_pd_cfg = 1'b0;
   logic [DW-1:0] clkdiv_cfg = '0;
   logic tmr_en = 1'b0, tmr_irq = 1'b0;
   logic spi_wake_en = 1'b0, spi_ie = 1'b0, spi_irq = 1'b0;
   logic ext0_wake_en = 1'b0, ext0_ie = 1'b0, ext0_irq = 1'b0;

   logic core_rst_n, in_pd, osc_pwr_on, pll_locked, core_clk_en, wake_pulse;
   logic [DW-1:0] core_div;
   logic [7:0] ctrl_rd;
   logic [1:0] wake_src;

   int n_tests = 0;
   int n_fail  = 0;
   int n_pulses = 0;
   int last_src = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pd_wake_ctrl #(
      .LOCK_TICKS(LOCK_T), .XTAL_TICKS(XTAL_T), .RST_TICKS(RST_T), .DIV_W(DW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .pd_req(pd_req),
      .osc_pd_cfg(osc_pd_cfg), .clkdiv_cfg(clkdiv_cfg),
      .tmr_en(tmr_en), .tmr_irq(tmr_irq),
      .spi_wake_en(spi_wake_en), .spi_ie(spi_ie), .spi_irq(spi_irq),
      .ext0_wake_en(ext0_wake_en), .ext0_ie(ext0_ie), .ext0_irq(ext0_irq),
      .core_rst_n(core_rst_n), .in_pd(in_pd), .osc_pwr_on(osc_pwr_on),
      .pll_locked(pll_locked), .core_div(core_div), .core_clk_en(core_clk_en),
      .ctrl_rd(ctrl_rd), .wake_pulse(wake_pulse), .wake_src(wake_src)
   );

   // ---------------- behavioural reference ----------------
   // phases: 0 hold, 1 running, 2 halted, 3 crystal wait, 4 lock wait
   int m_phase = 0, m_ticks = 0, m_dc = 0, m_div = 0, m_src = 0;
   bit m_osc_off = 0, m_lock = 0, m_pulse = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_ticks = 0; m_dc = 0; m_div = 0; m_src = 0;
         m_osc_off = 0; m_lock = 0; m_pulse = 0;
      end else begin
         bit awake;
         bit t_ok, s_ok, e_ok;
         awake = (m_phase == 1 || m_phase == 3 || m_phase == 4);
         m_dc = awake ? ((m_dc + 1) & 127) : 0;
         m_pulse = 0; m_src = 0;
         if (m_phase == 0) begin
            if (tick_32k) m_ticks++;
            if (m_ticks == RST_T) begin m_phase = 1; m_lock = 1; m_ticks = 0; end
         end else if (m_phase == 2) begin
            t_ok = tmr_irq && tmr_en && !m_osc_off;
            s_ok = spi_irq && spi_ie && spi_wake_en;
            e_ok = ext0_irq && ext0_ie && ext0_wake_en;
            if (t_ok || s_ok || e_ok) begin
               m_pulse = 1;
               m_src = t_ok ? 1 : (s_ok ? 2 : 3);
               m_phase = m_osc_off ? 3 : 4;
               m_ticks = 0;
            end
         end else if (pd_req) begin
            m_phase = 2; m_lock = 0; m_osc_off = osc_pd_cfg; m_ticks = 0;
         end else if (m_phase == 3) begin
            if (tick_32k) m_ticks++;
            if (m_ticks == XTAL_T) begin m_phase = 4; m_ticks = 0; end
         end else if (m_phase == 4) begin
            if (tick_32k) m_ticks++;
            if (m_ticks == LOCK_T) begin m_phase = 1; m_lock = 1; m_ticks = 0; end
         end
         m_div = int'(clkdiv_cfg);
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the rising edge
   always @(negedge clk) begin
      if (!done) begin
         bit awake;
         int exp_ctrl;
         awake = (m_phase == 1 || m_phase == 3 || m_phase == 4);
         exp_ctrl = (int'(m_lock) << 6) | (int'(osc_pd_cfg) << 4) | m_div;
         chk("R1 core_rst_n", int'(core_rst_n), int'(m_phase != 0));
         chk("R2 in_pd", int'(in_pd), int'(m_phase == 2));
         chk("R3 osc_pwr_on", int'(osc_pwr_on), int'(!(m_phase == 2 && m_osc_off)));
         chk("R9/R10 pll_locked", int'(pll_locked), int'(m_lock));
         chk("R7 wake_pulse", int'(wake_pulse), int'(m_pulse));
         chk("R7 wake_src", int'(wake_src), m_src);
         chk("R11 ctrl_rd", int'(ctrl_rd), exp_ctrl);
         chk("R12 core_clk_en", int'(core_clk_en),
             int'(awake && ((m_dc & ((1 << m_div) - 1)) == 0)));
         if (wake_pulse) begin
            n_pulses++;
            last_src = int'(wake_src);
         end
      end
   end

   // ---------------- stimulus ----------------
   initial begin : tick_gen
      forever begin
         for (int k = 0; k < TICK_EVERY; k++) begin
            @(negedge clk); #1;
            tick_32k = (k == TICK_EVERY - 1);
         end
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic pulse_pd(input bit osc_off);
      osc_pd_cfg = osc_off;
      pd_req = 1'b1;
      step(1);
      pd_req = 1'b0;
   endtask

   task automatic wait_lock();
      for (int i = 0; i < 400 && !pll_locked; i++) step(1);
   endtask

   task automatic fire(input bit t, input bit s, input bit e);
      tmr_irq = t; spi_irq = s; ext0_irq = e;
      step(1);
      tmr_irq = 0; spi_irq = 0; ext0_irq = 0;
   endtask

   initial begin : main
      int pc;
      rst_n = 1'b0;
      step(1);
      pd_req = 1'b1;                       // R13: request during reset
      step(2);
      chk("R1 hold core_rst_n", int'(core_rst_n), 0);
      chk("R1 hold pll_locked", int'(pll_locked), 0);
      chk("R1 hold osc_pwr_on", int'(osc_pwr_on), 1);
      chk("R1 hold wake_pulse", int'(wake_pulse), 0);
      rst_n = 1'b1;
      step(3);
      chk("R13 pd_req in hold", int'(in_pd), 0);
      pd_req = 1'b0;
      wait_lock();
      chk("R1 released", int'(core_rst_n), 1);

      clkdiv_cfg = 3'd2; step(12);
      clkdiv_cfg = 3'd0; step(3);

      // R8: interrupts while running
      pc = n_pulses;
      tmr_en = 1; spi_ie = 1; spi_wake_en = 1; ext0_ie = 1; ext0_wake_en = 1;
      fire(1, 1, 1); step(2);
      chk("R8 no pulse while running", n_pulses, pc);

      // halt with oscillator kept; gated sources must not wake
      pulse_pd(1'b0);
      chk("R2 halted", int'(in_pd), 1);
      spi_wake_en = 0; fire(0, 1, 0); step(2);
      chk("R5 spi without wake enable", int'(in_pd), 1);
      spi_wake_en = 1; spi_ie = 0; fire(0, 1, 0); step(2);
      chk("R5 spi without irq enable", int'(in_pd), 1);
      ext0_wake_en = 0; fire(0, 0, 1); step(2);
      chk("R6 ext0 without wake enable", int'(in_pd), 1);
      ext0_wake_en = 1; ext0_ie = 0; fire(0, 0, 1); step(2);
      chk("R6 ext0 without irq enable", int'(in_pd), 1);
      tmr_en = 0; fire(1, 0, 0); step(2);
      chk("R4 timer disabled", int'(in_pd), 1);
      pulse_pd(1'b1);
      chk("R13 pd_req while halted", int'(osc_pwr_on), 1);
      tmr_en = 1; spi_ie = 1; ext0_ie = 1;
      fire(1, 1, 1);
      chk("R7 all sources -> timer", last_src, 1);
      wait_lock();
      chk("R9 locked after wake", int'(pll_locked), 1);

      // halt with oscillator off: timer cannot wake, ext0 can
      pulse_pd(1'b1);
      chk("R3 oscillator off", int'(osc_pwr_on), 0);
      fire(1, 0, 0); step(3);
      chk("R4 timer with oscillator off", int'(in_pd), 1);
      fire(0, 0, 1);
      chk("R6 ext0 wakes", last_src, 3);
      wait_lock();
      chk("R10 locked after crystal", int'(pll_locked), 1);

      // SPI beats ext0; new halt requested during lock wait
      pulse_pd(1'b0);
      fire(0, 1, 1);
      chk("R7 spi over ext0", last_src, 2);
      step(2);
      pulse_pd(1'b0);
      chk("R2 halt during lock wait", int'(in_pd), 1);
      fire(0, 1, 0);
      chk("R5 spi wakes", last_src, 2);
      wait_lock();

      clkdiv_cfg = 3'd3; step(20);
      clkdiv_cfg = 3'd1; step(6);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : watchdog
      for (int i = 0; i < 100000; i++) @(posedge clk);
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule